// File: doc/BRIEF.md
# System Reset Control Port

This block is a single byte-wide I/O register on a simple read/write bus. It answers only at I/O address 0xCF9. Software uses it in two ways. It can store a reset-type flag, which is bit 1 of the register. It can also ask for a system reset by writing a byte with bit 2 set. The block does not sequence the reset itself. It emits a one-cycle request pulse, and a reset controller elsewhere acts on that pulse.

The design has three parts:
- an address decoder that qualifies the read and write strobes;
- a storage stage that keeps only the reset-type bit;
- a small pulse state machine that shapes the request.

The state machine has two states:
- `PS_IDLE` is the quiet state.
- `PS_FIRE` is the state in which the request output is high.

It has two transitions:
- `PS_IDLE -> PS_FIRE` is taken on the clock edge that accepts a trigger write.
- `PS_FIRE -> PS_IDLE` is always taken on the next edge.

Read data is combinational. It shows the stored byte only while the read strobe is high and the address matches. In every other case it is zero.

Top module: `sys_reset_port`

## Requirements
- R1: Only an access whose full 16-bit address equals 0xCF9 reaches the register. Any other address, including one differing in a single bit, does not.
- R2: A write accepted with bit 2 of the data set (a trigger write) leaves the stored byte unchanged.
- R3: A write accepted with bit 2 clear loads the stored byte with the write data ANDed with 0x02. Every bit except bit 1 becomes zero.
- R4: While the read strobe is high and the address is 0xCF9, the read data equals the stored byte. While the read strobe is low, the read data is zero.
- R5: Reset clears the stored byte to 0x00 and holds the request output low.
- R6: A trigger write accepted on clock edge N raises the request output from edge N to edge N+1, for exactly one cycle.
- R7: A read or write at any address other than 0xCF9 changes neither the stored byte nor the request output, and the read data stays zero.
- R8: A trigger write accepted while the request output is already high is dropped. The pulse still ends after one cycle, and no second pulse follows.
- R9: A write is accepted only on a rising clock edge with the write strobe high. Address and data presented without the strobe have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wdata | input | 8 | Write data byte |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data; zero unless a matching read is active |
| rst_req | output | 1 | One-cycle system-reset request pulse |

## Verification
The assertions take for granted three things about the inputs:
- the strobes and address are driven to known values whenever reset is released;
- a write is held stable across the clock edge that samples it;
- the read data is only judged while address and strobe are settled.

The bench keeps within these assumptions. It changes every input on the falling clock edge and samples the outputs shortly after it, so no value is in transit at the rising edge. It never drives the strobes to unknown values. It sweeps all 256 write values at the register address and flips each of the 16 address bits in turn to test decoding.

// File: rtl/sys_reset_pkg.sv
package sys_reset_pkg;

    // State of the request-pulse shaper
    typedef enum logic [0:0] {
        PS_IDLE = 1'b0,
        PS_FIRE = 1'b1
    } pulse_state_t;

    localparam int unsigned DEF_ADDR_W = 16;
    localparam int unsigned DEF_DATA_W = 8;

endpackage

// File: rtl/sys_reset_decode.sv
module sys_reset_decode #(
    parameter int unsigned ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0CF9
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic              wr_hit,
    output logic              rd_hit
);

    logic match;

    // Full-width compare: every address bit takes part
    assign match  = (io_addr == PORT_ADDR);
    assign wr_hit = match && io_wr;
    assign rd_hit = match && io_rd;

endmodule

// File: rtl/sys_reset_store.sv
module sys_reset_store #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned TRIG_BIT = 2,
    parameter int unsigned TYPE_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] stored,
    output logic              trig
);

    localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'(1) << TYPE_BIT;

    logic trig_wr;
    logic load_wr;

    assign trig_wr = wr_hit && wdata[TRIG_BIT];
    assign load_wr = wr_hit && !wdata[TRIG_BIT];
    assign trig    = trig_wr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stored <= '0;
        end else if (load_wr) begin
            stored <= wdata & KEEP_MASK;
        end
    end

    // R2: a trigger write must not disturb the stored byte
    p_trig_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wdata[TRIG_BIT]) |=> $stable(stored));

    // R7 / R9: nothing changes without a qualified write
    p_no_write_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(stored));

    // R3: after a plain write only the type bit may survive
    p_type_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !wdata[TRIG_BIT]) |=> ((stored & ~KEEP_MASK) == '0));

endmodule

// File: rtl/sys_reset_pulse.sv
module sys_reset_pulse
    import sys_reset_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic rst_req
);

    pulse_state_t state_q;
    pulse_state_t state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and output
    always_comb begin
        state_d = state_q;
        rst_req = 1'b0;
        unique case (state_q)
            PS_IDLE: begin
                if (trig) begin
                    state_d = PS_FIRE;
                end
            end
            PS_FIRE: begin
                rst_req = 1'b1;
                state_d = PS_IDLE;   // a trigger arriving here is dropped (R8)
            end
            default: begin
                state_d = PS_IDLE;
            end
        endcase
    end

    // R6 / R8: the request never lasts longer than one cycle
    p_single_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R6: every rising request is caused by a trigger on the previous edge
    p_pulse_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(trig));

endmodule

// File: rtl/sys_reset_port.sv
module sys_reset_port
    import sys_reset_pkg::*;
#(
    parameter int unsigned ADDR_W    = DEF_ADDR_W,
    parameter int unsigned DATA_W    = DEF_DATA_W,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0CF9,
    parameter int unsigned TRIG_BIT  = 2,
    parameter int unsigned TYPE_BIT  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic [DATA_W-1:0] io_rdata,
    output logic              rst_req
);

    logic              wr_hit;
    logic              rd_hit;
    logic              trig;
    logic [DATA_W-1:0] stored;

    sys_reset_decode #(
        .ADDR_W    (ADDR_W),
        .PORT_ADDR (PORT_ADDR)
    ) u_decode (
        .io_addr (io_addr),
        .io_wr   (io_wr),
        .io_rd   (io_rd),
        .wr_hit  (wr_hit),
        .rd_hit  (rd_hit)
    );

    sys_reset_store #(
        .DATA_W   (DATA_W),
        .TRIG_BIT (TRIG_BIT),
        .TYPE_BIT (TYPE_BIT)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (wr_hit),
        .wdata  (io_wdata),
        .stored (stored),
        .trig   (trig)
    );

    sys_reset_pulse u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig    (trig),
        .rst_req (rst_req)
    );

    // Readback: zero unless a matching read is in progress
    assign io_rdata = rd_hit ? stored : '0;

    // R4 / R7: read data is zero outside a matching read
    p_rdata_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && (io_addr == PORT_ADDR)) |-> (io_rdata == '0));

    // R9: without a write strobe no new request can start
    p_strobe_needed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !io_wr |=> !$rose(rst_req));

    // R1: a write to another address cannot start a request
    p_decode_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr != PORT_ADDR) |=> !$rose(rst_req));

endmodule

// File: tb/sys_reset_port_test.sv
`timescale 1ns/1ps
module sys_reset_port_test;

    localparam logic [15:0] PORT = 16'h0CF9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_rdata;
    logic        rst_req;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic [7:0] model = '0;

    always #2 clk = ~clk;

    sys_reset_port uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_rdata (io_rdata),
        .rst_req  (rst_req)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Present a write for one rising edge; returns after the following falling edge
    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        #0.5;
    endtask

    task automatic read_val(input logic [15:0] a, output logic [7:0] v);
        io_addr = a; io_rd = 1'b1;
        #0.5;
        v = io_rdata;
        io_rd = 1'b0;
        #0.2;
    endtask

    initial begin
        logic [7:0] rv;

        // R5: reset state
        repeat (3) @(negedge clk);
        check(rst_req == 1'b0, "R5 request low in reset", rst_req, 0);
        rst_n = 1'b1;
        @(negedge clk); #0.5;
        read_val(PORT, rv);
        check(rv == 8'h00, "R5 stored cleared", rv, 0);
        check(rst_req == 1'b0, "R5 request low after reset", rst_req, 0);

        // R4: no read strobe gives zero even with stored type bit set
        do_write(PORT, 8'h02);
        model = 8'h02;
        io_addr = PORT; #0.5;
        check(io_rdata == 8'h00, "R4 zero without read strobe", io_rdata, 0);

        // R2 R3 R6: sweep all byte values
        for (int v = 0; v < 256; v++) begin
            logic [7:0] d;
            logic       t;
            d = 8'(v);
            t = d[2];
            do_write(PORT, d);
            check(rst_req == t, "R6 pulse in cycle after write", rst_req, t);
            if (!t) model = d & 8'h02;
            @(negedge clk); #0.5;
            check(rst_req == 1'b0, "R6 pulse one cycle only", rst_req, 0);
            read_val(PORT, rv);
            if (t) check(rv == model, "R2 trigger keeps stored", rv, model);
            else   check(rv == model, "R3 stored masked to bit 1", rv, model);
        end

        // R8: back-to-back trigger writes give a single pulse
        do_write(PORT, 8'h02);
        model = 8'h02;
        @(negedge clk);
        io_addr = PORT; io_wdata = 8'h04; io_wr = 1'b1;
        @(negedge clk); #0.5;
        check(rst_req == 1'b1, "R8 first pulse", rst_req, 1);
        @(negedge clk);
        io_wr = 1'b0;
        #0.5;
        check(rst_req == 1'b0, "R8 second trigger dropped", rst_req, 0);
        @(negedge clk); #0.5;
        check(rst_req == 1'b0, "R8 no late pulse", rst_req, 0);
        read_val(PORT, rv);
        check(rv == model, "R8 stored unchanged", rv, model);

        // R1 R7: single-bit address flips are misses
        for (int b = 0; b < 16; b++) begin
            logic [15:0] a;
            a = PORT ^ (16'h1 << b);
            do_write(a, 8'h00);
            read_val(PORT, rv);
            check(rv == model, "R1 miss write keeps stored", rv, model);
            do_write(a, 8'h04);
            check(rst_req == 1'b0, "R7 miss trigger no pulse", rst_req, 0);
            read_val(a, rv);
            check(rv == 8'h00, "R7 miss read is zero", rv, 0);
        end

        // R9: data and address without write strobe
        @(negedge clk);
        io_addr = PORT; io_wdata = 8'h00; io_wr = 1'b0;
        @(negedge clk);
        io_wdata = 8'h04;
        @(negedge clk); #0.5;
        check(rst_req == 1'b0, "R9 no pulse without strobe", rst_req, 0);
        read_val(PORT, rv);
        check(rv == model, "R9 stored unchanged without strobe", rv, model);

        // R5: reset mid-run clears stored type bit
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model = 8'h00;
        #0.5;
        read_val(PORT, rv);
        check(rv == 8'h00, "R5 reset clears stored", rv, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule